// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight interrupt sources for a small processor and presents them on one interrupt line. A rising edge on any source input is captured as a pending request. A resolver picks the most urgent pending request and compares it with the sources whose handlers are already running. The line to the processor is raised only when the pending request outranks every running handler. Because of this rule, a handler can be pre-empted only by a strictly more urgent source.

The processor acknowledges with two low pulses on an active-low strobe, which is sampled in the system clock domain. The first pulse commits the winning source: its in-service bit is set and its pending bit is cleared. The second pulse places an 8-bit vector on the output data lines and enables the pad driver. The driver is released when the strobe returns high.

Software uses a small write port for three things: it sets the vector base, it sets which source is most urgent, and it issues end-of-interrupt commands. An end-of-interrupt retires the most urgent running handler, and this can let a blocked request through.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A low-to-high transition on `req_in[n]` marks source n pending. A request held high produces one request only. A new one needs a new rising edge.
- R2: When several sources are pending and none is in service, the most urgent pending source is the one committed and vectored.
- R3: A pending source is blocked while any in-service source has equal or higher urgency. A strictly more urgent source still raises `irq` while a handler runs.
- R4: `irq` is high while the sequencer is idle and an unblocked pending source exists, and low otherwise outside an acknowledge.
- R5: On the first falling strobe edge, the winner's in-service bit is set and its pending bit is cleared. `vec_drive` stays low and `irq` stays high.
- R6: On the second falling strobe edge, `vec_drive` goes high with the vector on `vec_data`, and `irq` goes low.
- R7: `vec_drive` returns low after the strobe goes high again.
- R8: A write to address 2 is an end-of-interrupt. It clears only the most urgent set in-service bit, and in-service bits clear in no other way.
- R9: After an end-of-interrupt, a pending source that is no longer blocked raises `irq` again.
- R10: The vector is `{base, source index}`. `base` is 5 bits, loaded from `wr_data[7:3]` by a write to address 0.
- R11: A write to address 1 loads `wr_data[2:0]` as the most urgent source. The urgency rank of source s is (s - that value) mod 8, and rank 0 is the most urgent.
- R12: After reset, `irq` and `vec_drive` are low, the base is 0, the most urgent source is 0, and no source is pending or in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 8 | Asynchronous interrupt source inputs, edge sensitive |
| ack_n | input | 1 | Active-low acknowledge strobe from the processor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 base, 1 urgency origin, 2 end-of-interrupt |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Interrupt request to the processor |
| vec_data | output | 8 | Vector value for the data bus |
| vec_drive | output | 1 | Output enable for the data bus pad driver |

## Verification
The hardest states to reach from the ports are those with two nested handlers in service and a third request pending underneath them. In that state a single end-of-interrupt must retire only the inner handler while the lower request stays blocked, and a second one must release it. The stimulus reaches it by committing source 4 and then raising source 6, which must stay silent. It then raises source 2, which must pre-empt, and finally issues end-of-interrupts one at a time while checking `irq` after each. The same pattern is repeated after the urgency origin is rotated, so that a source with a higher index outranks a lower one.

// File: rtl/nic_pkg.sv
// Package: shared types and register addresses for the nested interrupt controller.
// Assumes a single clock domain; addresses are decoded by the top module.
package nic_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_GOT1  = 2'd1,
        SQ_DRIVE = 2'd2
    } seq_st_t;

    localparam logic [1:0] RA_BASE = 2'd0;
    localparam logic [1:0] RA_ORIG = 2'd1;
    localparam logic [1:0] RA_EOI  = 2'd2;
endpackage

// File: rtl/nic_sync.sv
// Two-flop synchronizer with one extra delayed copy for edge detection.
// Assumes inputs may be asynchronous; RST_VAL sets the idle level.
module nic_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] meta;

    // Purpose: move the input into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
            q_d  <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
            q_d  <= q;
        end
    end
endmodule

// File: rtl/nic_prio_pick.sv
// Finds the most urgent set bit of a vector under a rotating urgency origin.
// Assumes N is a power of two so index arithmetic wraps naturally.
module nic_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] orig,
    output logic          found,
    output logic [IW-1:0] sel,
    output logic [IW-1:0] rank
);
    logic [IW-1:0] idx;

    // Purpose: scan ranks from least to most urgent so the most urgent hit is kept.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        rank  = '0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = orig + IW'(k);
            if (vec[idx]) begin
                found = 1'b1;
                sel   = idx;
                rank  = IW'(k);
            end
        end
    end
endmodule

// File: rtl/nic_seq.sv
// Acknowledge sequencer: first strobe edge commits, second presents the vector.
// Assumes edge pulses are one cycle wide and come from synchronized samples.
module nic_seq
    import nic_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_fall,
    input  logic          ack_rise,
    input  logic          win_valid,
    input  logic [IW-1:0] win_sel,
    output logic          commit,
    output logic [IW-1:0] cur_sel,
    output seq_st_t       st
);
    // Purpose: a commit happens only on the first edge and only with a winner.
    assign commit = (st == SQ_IDLE) && ack_fall && win_valid;

    // Purpose: advance through the two-pulse handshake and hold the serviced index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            cur_sel <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (commit) begin
                    st      <= SQ_GOT1;
                    cur_sel <= win_sel;
                end
                SQ_GOT1:  if (ack_fall) st <= SQ_DRIVE;
                SQ_DRIVE: if (ack_rise) st <= SQ_IDLE;
                default:  st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
// Top: eight-source fully nested interrupt controller with a two-pulse acknowledge.
// Assumes req_in and ack_n are asynchronous; all state uses clk with sync reset.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_in,
    input  logic             ack_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic             irq,
    output logic [VEC_W-1:0] vec_data,
    output logic             vec_drive
);
    localparam int IW = $clog2(N_SRC);
    localparam int BW = VEC_W - IW;

    logic [N_SRC-1:0] req_s, req_d, req_rise;
    logic             ack_s, ack_d, ack_fall, ack_rise;
    logic [N_SRC-1:0] irr, isr, commit_mask, eoi_mask;
    logic [BW-1:0]    base;
    logic [IW-1:0]    orig;
    logic             irr_found, isr_found, fwd, commit, eoi_wr;
    logic [IW-1:0]    irr_sel, irr_rank, isr_sel, isr_rank, cur_sel;
    seq_st_t          st;

    nic_sync #(.W(N_SRC), .RST_VAL('0)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_in), .q(req_s), .q_d(req_d)
    );
    nic_sync #(.W(1), .RST_VAL(1'b1)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_s), .q_d(ack_d)
    );

    // Purpose: edge pulses from the synchronized samples.
    assign req_rise = req_s & ~req_d;
    assign ack_fall = ack_d & ~ack_s;
    assign ack_rise = ack_s & ~ack_d;

    nic_prio_pick #(.N(N_SRC), .IW(IW)) u_pick_req (
        .vec(irr), .orig(orig), .found(irr_found), .sel(irr_sel), .rank(irr_rank)
    );
    nic_prio_pick #(.N(N_SRC), .IW(IW)) u_pick_svc (
        .vec(isr), .orig(orig), .found(isr_found), .sel(isr_sel), .rank(isr_rank)
    );

    // Purpose: nested gate, the pending winner must strictly outrank all running handlers.
    assign fwd = irr_found && (!isr_found || (irr_rank < isr_rank));

    nic_seq #(.IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ack_fall(ack_fall), .ack_rise(ack_rise),
        .win_valid(fwd), .win_sel(irr_sel), .commit(commit), .cur_sel(cur_sel), .st(st)
    );

    assign eoi_wr = wr_en && (wr_addr == RA_EOI);

    // Purpose: one-hot masks for commit and end-of-interrupt updates.
    always_comb begin
        commit_mask = '0;
        eoi_mask    = '0;
        if (commit)               commit_mask[irr_sel] = 1'b1;
        if (eoi_wr && isr_found)  eoi_mask[isr_sel]    = 1'b1;
    end

    // Purpose: pending and in-service registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= (irr & ~commit_mask) | req_rise;
            isr <= (isr | commit_mask) & ~eoi_mask;
        end
    end

    // Purpose: software-written vector base and urgency origin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            orig <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_BASE) base <= wr_data[7:8-BW];
            if (wr_addr == RA_ORIG) orig <= wr_data[IW-1:0];
        end
    end

    // Purpose: processor-facing outputs.
    assign irq       = ((st == SQ_IDLE) && fwd) || (st == SQ_GOT1);
    assign vec_drive = (st == SQ_DRIVE);
    assign vec_data  = {base, cur_sel};
endmodule

// File: rtl/nic_checker.sv
// Checker: temporal properties of the nested controller, bound into the top.
// Assumes it observes the top's internal pending/in-service registers and state.
module nic_checker
    import nic_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       vec_drive,
    input logic       ack_rise,
    input logic       eoi_wr,
    input logic [1:0] st,
    input logic [7:0] irr,
    input logic [7:0] isr
);
    AST_DRIVE_MUTES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        vec_drive |-> !irq); // R6
    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr & ~$past(isr)) <= 1); // R5
    AST_CLEAR_ONLY_ON_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(isr) & ~isr)) |-> $past(eoi_wr)); // R8
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(isr) & ~isr) <= 1); // R8
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && vec_drive) |=> !vec_drive); // R7
    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (st == 2'(SQ_IDLE))) |-> (|irr)); // R4
endmodule

bind nest_irq_ctrl nic_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .vec_drive(vec_drive),
    .ack_rise(ack_rise), .eoi_wr(eoi_wr), .st(st), .irr(irr), .isr(isr)
);

// File: tb/nest_irq_ctrl_tb.sv
// Scoreboard bench: the acknowledge driver queues expected vectors, a monitor compares.
module nest_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0;
    logic       ack_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       irq;
    logic [7:0] vec_data;
    logic       vec_drive;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [4:0] exp_base = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       drv_prev = 1'b0;

    always #5 clk = ~clk;

    nest_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_n(ack_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .vec_data(vec_data), .vec_drive(vec_drive)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [7:0] m);
        @(negedge clk);
        req_in = m;
        repeat (4) @(negedge clk);
        req_in = '0;
        repeat (4) @(negedge clk);
    endtask

    // Driver: runs one two-pulse acknowledge and queues the expected vector.
    task automatic ack_cycle(input logic [2:0] src, input string tag);
        exp_q.push_back({exp_base, src});
        tag_q.push_back(tag);
        @(negedge clk);
        ack_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 bus idle after first pulse", {7'd0, vec_drive}, 8'd0);
        chk("R5 irq held after first pulse", {7'd0, irq}, 8'd1);
        ack_n = 1'b1;
        repeat (6) @(negedge clk);
        ack_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R6 bus driven after second pulse", {7'd0, vec_drive}, 8'd1);
        chk("R6 irq dropped after second pulse", {7'd0, irq}, 8'd0);
        ack_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 bus released", {7'd0, vec_drive}, 8'd0);
    endtask

    // Monitor: compares the vector each time the driver enable rises.
    always @(negedge clk) begin
        if (vec_drive && !drv_prev) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected vector", vec_data, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), vec_data, exp_q.pop_front());
            end
        end
        drv_prev = vec_drive;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 irq after reset", {7'd0, irq}, 8'd0);
        chk("R12 drive after reset", {7'd0, vec_drive}, 8'd0);

        // Single source, default base and origin.
        pulse_req(8'h10);
        chk("R1 R4 irq on edge of source 4", {7'd0, irq}, 8'd1);
        ack_cycle(3'd4, "R10 R12 vector of source 4");

        // Nesting: lower blocked, higher pre-empts.
        pulse_req(8'h40);
        chk("R3 lower source 6 blocked by 4", {7'd0, irq}, 8'd0);
        pulse_req(8'h04);
        chk("R3 higher source 2 pre-empts", {7'd0, irq}, 8'd1);
        ack_cycle(3'd2, "R3 vector of source 2");
        wr(2'd2, 8'h00);
        chk("R8 first eoi leaves 4 in service", {7'd0, irq}, 8'd0);
        wr(2'd2, 8'h00);
        chk("R9 second eoi releases source 6", {7'd0, irq}, 8'd1);
        ack_cycle(3'd6, "R9 vector of source 6");
        pulse_req(8'h40);
        chk("R3 equal source 6 blocked", {7'd0, irq}, 8'd0);
        wr(2'd2, 8'h00);
        chk("R9 eoi releases repeated 6", {7'd0, irq}, 8'd1);
        ack_cycle(3'd6, "R9 vector of repeated 6");
        wr(2'd2, 8'h00);
        chk("R5 no stale requests remain", {7'd0, irq}, 8'd0);

        // Simultaneous requests, default order.
        pulse_req(8'h22);
        ack_cycle(3'd1, "R2 source 1 beats 5");
        chk("R3 source 5 blocked under 1", {7'd0, irq}, 8'd0);
        wr(2'd2, 8'h00);
        ack_cycle(3'd5, "R9 source 5 after eoi");
        wr(2'd2, 8'h00);

        // Rotated urgency and new base.
        wr(2'd0, 8'hA8);
        exp_base = 5'd21;
        wr(2'd1, 8'h05);
        pulse_req(8'h44);
        ack_cycle(3'd6, "R11 R10 source 6 beats 2 under origin 5");
        chk("R11 source 2 blocked under 6", {7'd0, irq}, 8'd0);
        wr(2'd2, 8'h00);
        ack_cycle(3'd2, "R10 vector of source 2 with base");
        wr(2'd2, 8'h00);

        // Held level gives one request only.
        wr(2'd1, 8'h00);
        @(negedge clk);
        req_in = 8'h08;
        repeat (6) @(negedge clk);
        ack_cycle(3'd3, "R1 held source 3 first request");
        wr(2'd2, 8'h00);
        repeat (6) @(negedge clk);
        chk("R1 held level no second request", {7'd0, irq}, 8'd0);
        req_in = '0;
        repeat (6) @(negedge clk);

        chk("R6 all vectors seen", 8'(exp_q.size()), 8'd0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R12 watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule